// File: doc/BRIEF.md
# Time-of-Day Update Engine

This block keeps a calendar clock of seven byte fields (seconds, minutes, hours, day of week, day of month, month and two-digit year) and moves it forward one second each time a one-hertz tick arrives. Each update is announced: an update-in-progress flag rises as soon as the tick is accepted, the fields change a fixed number of clock cycles later, and the flag stays high for a further fixed busy time. In the cycle in which the flag falls, a one-cycle end-of-update pulse is issued. Both lengths are parameters counted in cycles of the block clock. At the default values, with a 32.768 kHz clock, they give a warning window of about 244 µs and a total flag time of about 2.2 ms.

A host write port loads any field and a control byte. The control byte selects BCD or binary storage and 12-hour or 24-hour hours. It also holds a freeze bit. While the freeze bit is set, no update starts, and an update already running is abandoned, so the host can load a new time safely. Carries run through month lengths, leap years (every year divisible by four), the wrap from December to January, the two-digit year wrap and the day-of-week cycle.

Top module: `tod_update_engine`

## Requirements
- R1: After reset the fields are seconds 0, minutes 0, hours 0, day of week 1, day of month 1, month 1, year 0. The control byte is 0x02 (24-hour, BCD, not frozen). The in-progress flag and the end pulse are low.
- R2: A tick sampled while idle and not frozen sets the in-progress flag from the next cycle on. The flag stays high for exactly LEAD_CYC + BUSY_CYC cycles. Ticks that arrive while the flag is high are ignored.
- R3: Fields change only at the clock edge that ends the LEAD_CYC-th cycle of a high flag, or when the host writes them. Otherwise they hold their value.
- R4: The end pulse is high for exactly one cycle: the first cycle in which the flag is low again after a completed update.
- R5: While control bit 7 (freeze) is 1, no update starts. If it becomes 1 during an update, the flag drops on the next edge, no end pulse follows, and a field change that has not yet happened is skipped.
- R6: Host writes use these addresses: 0 seconds, 2 minutes, 4 hours, 6 day of week, 7 day of month, 8 month, 9 year, 11 control byte. A write takes effect at the next edge. Writes to any other address change nothing. A write on the edge where the fields advance wins for the field it addresses.
- R7: Control bit 2 = 0 stores every field in BCD (seconds 0x09 -> 0x10, 0x59 -> 0x00 with carry). Bit 2 = 1 stores plain binary (0x09 -> 0x0A, 0x3B -> 0x00 with carry).
- R8: Control bit 1 = 1 selects 24-hour hours 0..23. Hour 23 wraps to 0 and carries into the day.
- R9: Control bit 1 = 0 selects 12-hour hours 1..12, with hour-byte bit 7 set for PM. In BCD, 0x11 -> 0x92 (11 AM to 12 PM), 0x92 -> 0x81 (12 PM to 1 PM), and 0x91 -> 0x12 (11 PM to 12 AM) with a day carry.
- R10: Day of month wraps to 1 after the last day of the month: 30 for months 4, 6, 9 and 11, otherwise 31, except month 2, which has 29 days when year mod 4 = 0 and 28 days otherwise. The wrap carries into the month.
- R11: Month 12 wraps to 1 and carries into the year. Year 99 wraps to 0. Day of week goes 1..7 and back to 1, and advances on every day carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; durations are counted in its cycles |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_1hz | input | 1 | One-cycle pulse once per second |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 4 | Host write address |
| wr_data | input | 8 | Host write data |
| sec_o | output | 8 | Seconds field |
| min_o | output | 8 | Minutes field |
| hour_o | output | 8 | Hours field (bit 7 = PM in 12-hour form) |
| wday_o | output | 8 | Day-of-week field |
| mday_o | output | 8 | Day-of-month field |
| month_o | output | 8 | Month field |
| year_o | output | 8 | Year field |
| uip_o | output | 1 | Update-in-progress flag |
| upd_end_o | output | 1 | One-cycle end-of-update pulse |

## Verification
Two cases are hard to reach from the ports. The first is a host write that lands on the exact edge where the fields advance. The second is a freeze that arrives inside the warning window, before the advance. The bench counts falling edges from the tick it drives, so the write strobe, or the control write that sets the freeze bit, is sampled on a chosen edge. A behavioural model that runs beside the design checks every output on every cycle. Full carry chains are reached by loading times such as 23:59:59 on 31 December of year 99, or 11 PM in 12-hour form, and then issuing one tick.

// File: rtl/tod_pkg.sv
// tod_pkg: shared constants, slot numbering and BCD/binary helpers for the
// time-of-day update engine. Assumes fields never exceed 99 in value.
package tod_pkg;

    localparam int BYTE_W     = 8;
    localparam int VAL_W      = 7;
    localparam int NUM_FIELDS = 7;
    localparam int ADDR_W     = 4;

    localparam logic [ADDR_W-1:0] CTRL_ADDR = 4'd11;
    localparam int CTRL_FREEZE = 7;
    localparam int CTRL_BIN    = 2;
    localparam int CTRL_H24    = 1;
    localparam logic [BYTE_W-1:0] CTRL_RESET = 8'h02;

    typedef enum int {
        SL_SEC   = 0,
        SL_MIN   = 1,
        SL_HOUR  = 2,
        SL_WDAY  = 3,
        SL_MDAY  = 4,
        SL_MONTH = 5,
        SL_YEAR  = 6
    } slot_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LEAD = 2'd1,
        PH_BUSY = 2'd2
    } phase_e;

    // Host address of each field slot.
    function automatic logic [ADDR_W-1:0] slot_addr(input int s);
        case (s)
            SL_SEC:   return 4'd0;
            SL_MIN:   return 4'd2;
            SL_HOUR:  return 4'd4;
            SL_WDAY:  return 4'd6;
            SL_MDAY:  return 4'd7;
            SL_MONTH: return 4'd8;
            default:  return 4'd9;
        endcase
    endfunction

    // Value of each field slot after reset (same in BCD and binary).
    function automatic logic [BYTE_W-1:0] slot_reset(input int s);
        case (s)
            SL_WDAY, SL_MDAY, SL_MONTH: return 8'h01;
            default:                    return 8'h00;
        endcase
    endfunction

    // Two BCD digits to a binary value: tens*8 + tens*2 + ones.
    function automatic logic [VAL_W-1:0] bcd_to_bin(input logic [BYTE_W-1:0] b);
        logic [BYTE_W-1:0] t;
        t = 8'({b[7:4], 3'b000}) + 8'({b[7:4], 1'b0}) + 8'(b[3:0]);
        return t[VAL_W-1:0];
    endfunction

    // Binary value 0..99 to two BCD digits.
    function automatic logic [BYTE_W-1:0] bin_to_bcd(input logic [VAL_W-1:0] v);
        logic [VAL_W-1:0] tens;
        logic [VAL_W-1:0] ones;
        tens = v / 7'd10;
        ones = v - tens * 7'd10;
        return {tens[3:0], ones[3:0]};
    endfunction

    // Length of a month; February is long when the year is a multiple of 4.
    function automatic logic [VAL_W-1:0] month_days(input logic [VAL_W-1:0] mon,
                                                    input logic [VAL_W-1:0] yr);
        case (mon)
            7'd2:                      return (yr[1:0] == 2'b00) ? 7'd29 : 7'd28;
            7'd4, 7'd6, 7'd9, 7'd11:   return 7'd30;
            default:                   return 7'd31;
        endcase
    endfunction

endpackage

// File: rtl/tod_uip_sequencer.sv
// tod_uip_sequencer: turns an accepted one-hertz tick into the update
// timeline. The flag rises on the edge that accepts the tick; the advance
// strobe is high in the LEAD_CYC-th flagged cycle; the flag falls BUSY_CYC
// cycles later together with a one-cycle end pulse. A freeze abandons the
// timeline at once. Assumes LEAD_CYC >= 1 and BUSY_CYC >= 1.
module tod_uip_sequencer
    import tod_pkg::*;
#(
    parameter int LEAD_CYC = 8,
    parameter int BUSY_CYC = 65
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic freeze,
    output logic uip,
    output logic adv,
    output logic upd_end
);

    localparam int MAX_CYC = (LEAD_CYC > BUSY_CYC) ? LEAD_CYC : BUSY_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] LEAD_LAST = CNT_W'(LEAD_CYC - 1);
    localparam logic [CNT_W-1:0] BUSY_LAST = CNT_W'(BUSY_CYC - 1);

    phase_e           phase_q;
    logic [CNT_W-1:0] cnt_q;

    // Advance strobe: last cycle of the warning window, unless frozen.
    assign adv = (phase_q == PH_LEAD) && (cnt_q == '0) && !freeze;

    // Phase, window counter, flag and end pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            uip     <= 1'b0;
            upd_end <= 1'b0;
        end else begin
            upd_end <= 1'b0;
            if (freeze) begin
                phase_q <= PH_IDLE;
                cnt_q   <= '0;
                uip     <= 1'b0;
            end else begin
                case (phase_q)
                    PH_IDLE: begin
                        if (tick) begin
                            phase_q <= PH_LEAD;
                            cnt_q   <= LEAD_LAST;
                            uip     <= 1'b1;
                        end
                    end
                    PH_LEAD: begin
                        if (cnt_q == '0) begin
                            phase_q <= PH_BUSY;
                            cnt_q   <= BUSY_LAST;
                        end else begin
                            cnt_q <= cnt_q - 1'b1;
                        end
                    end
                    PH_BUSY: begin
                        if (cnt_q == '0) begin
                            phase_q <= PH_IDLE;
                            uip     <= 1'b0;
                            upd_end <= 1'b1;
                        end else begin
                            cnt_q <= cnt_q - 1'b1;
                        end
                    end
                    default: begin
                        phase_q <= PH_IDLE;
                        uip     <= 1'b0;
                    end
                endcase
            end
        end
    end

    AST_START_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(uip) |-> ($past(tick) && !$past(freeze))) else $error("flag rose without tick"); // R2
    AST_ADV_UNDER_UIP: assert property (@(posedge clk) disable iff (!rst_n)
        adv |-> uip) else $error("advance outside flag"); // R3
    AST_END_AFTER_UIP: assert property (@(posedge clk) disable iff (!rst_n)
        upd_end |-> (!uip && $past(uip))) else $error("end pulse misplaced"); // R4
    AST_FREEZE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        freeze |=> !uip) else $error("flag high while frozen"); // R5

endmodule

// File: rtl/tod_field_codec.sv
// tod_field_codec: converts one stored field byte to a binary value, and a
// next binary value back to the stored format (BCD or binary). For the hour
// field, bit 7 is the PM marker and is kept outside the number.
// Assumes values fit in 0..99.
module tod_field_codec
    import tod_pkg::*;
#(
    parameter bit IS_HOUR = 1'b0
) (
    input  logic [BYTE_W-1:0] raw,
    input  logic              bin_mode,
    input  logic [VAL_W-1:0]  nxt,
    input  logic              nxt_pm,
    output logic [VAL_W-1:0]  dec,
    output logic [BYTE_W-1:0] enc
);

    logic [BYTE_W-1:0] body;
    logic [BYTE_W-1:0] enc_body;

    // Decode the stored byte, stripping the PM marker on the hour field.
    always_comb begin
        body = IS_HOUR ? {1'b0, raw[6:0]} : raw;
        dec  = bin_mode ? body[VAL_W-1:0] : bcd_to_bin(body);
    end

    // Encode the next value, restoring the PM marker on the hour field.
    always_comb begin
        enc_body = bin_mode ? {1'b0, nxt} : bin_to_bcd(nxt);
        enc      = IS_HOUR ? {nxt_pm, enc_body[6:0]} : enc_body;
    end

endmodule

// File: rtl/tod_calendar_next.sv
// tod_calendar_next: from the present binary field values, computes the
// values one second later, with the full carry chain through the hour
// format, month length, leap year, year wrap and day of week.
// Purely combinational; assumes inputs are in range.
module tod_calendar_next
    import tod_pkg::*;
(
    input  logic             h24,
    input  logic [VAL_W-1:0] sec,
    input  logic [VAL_W-1:0] min,
    input  logic [VAL_W-1:0] hr,
    input  logic             pm,
    input  logic [VAL_W-1:0] wday,
    input  logic [VAL_W-1:0] mday,
    input  logic [VAL_W-1:0] month,
    input  logic [VAL_W-1:0] year,
    output logic [VAL_W-1:0] n_sec,
    output logic [VAL_W-1:0] n_min,
    output logic [VAL_W-1:0] n_hr,
    output logic             n_pm,
    output logic [VAL_W-1:0] n_wday,
    output logic [VAL_W-1:0] n_mday,
    output logic [VAL_W-1:0] n_month,
    output logic [VAL_W-1:0] n_year
);

    logic             c_min;
    logic             c_hr;
    logic             c_day;
    logic             c_mon;
    logic             c_yr;
    logic [VAL_W-1:0] days;

    // Seconds and minutes with their carries.
    always_comb begin
        c_min = (sec >= 7'd59);
        n_sec = c_min ? 7'd0 : sec + 7'd1;
        c_hr  = c_min && (min >= 7'd59);
        n_min = c_min ? (c_hr ? 7'd0 : min + 7'd1) : min;
    end

    // Hours in either format, giving the day carry.
    always_comb begin
        n_hr  = hr;
        n_pm  = h24 ? 1'b0 : pm;
        c_day = 1'b0;
        if (c_hr) begin
            if (h24) begin
                c_day = (hr >= 7'd23);
                n_hr  = c_day ? 7'd0 : hr + 7'd1;
            end else if (hr == 7'd11) begin
                n_hr  = 7'd12;
                n_pm  = !pm;
                c_day = pm;
            end else if (hr >= 7'd12) begin
                n_hr = 7'd1;
            end else begin
                n_hr = hr + 7'd1;
            end
        end
    end

    // Day of week, day of month, month and year.
    always_comb begin
        days    = month_days(month, year);
        c_mon   = c_day && (mday >= days);
        c_yr    = c_mon && (month >= 7'd12);
        n_wday  = c_day ? ((wday >= 7'd7) ? 7'd1 : wday + 7'd1) : wday;
        n_mday  = c_day ? (c_mon ? 7'd1 : mday + 7'd1) : mday;
        n_month = c_mon ? (c_yr ? 7'd1 : month + 7'd1) : month;
        n_year  = c_yr ? ((year >= 7'd99) ? 7'd0 : year + 7'd1) : year;
    end

    // Range guards on the wrapped fields.
    always_comb begin
        if (month >= 7'd1 && month <= 7'd12) begin
            AST_MONTH_RANGE: assert (n_month >= 7'd1 && n_month <= 7'd12)
                else $error("month out of range"); // R11
        end
        if (mday >= 7'd1 && mday <= days) begin
            AST_MDAY_RANGE: assert (n_mday >= 7'd1 && n_mday <= 7'd31)
                else $error("day of month out of range"); // R10
        end
    end

endmodule

// File: rtl/tod_update_engine.sv
// tod_update_engine: top of the time-of-day update engine. Holds the seven
// field bytes and the control byte, accepts host writes, and, on the
// sequencer's advance strobe, loads every field with its value one second
// later. A host write on the advance edge wins for its own field.
// Assumes tick_1hz is a single-cycle pulse synchronous to clk.
module tod_update_engine
    import tod_pkg::*;
#(
    parameter int LEAD_CYC = 8,
    parameter int BUSY_CYC = 65
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_1hz,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [BYTE_W-1:0] sec_o,
    output logic [BYTE_W-1:0] min_o,
    output logic [BYTE_W-1:0] hour_o,
    output logic [BYTE_W-1:0] wday_o,
    output logic [BYTE_W-1:0] mday_o,
    output logic [BYTE_W-1:0] month_o,
    output logic [BYTE_W-1:0] year_o,
    output logic              uip_o,
    output logic              upd_end_o
);

    logic [NUM_FIELDS-1:0][BYTE_W-1:0] field_q;
    logic [NUM_FIELDS-1:0][VAL_W-1:0]  dec;
    logic [NUM_FIELDS-1:0][VAL_W-1:0]  nxt;
    logic [NUM_FIELDS-1:0][BYTE_W-1:0] enc;
    logic [BYTE_W-1:0]                 ctrl_q;
    logic                              freeze;
    logic                              bin_mode;
    logic                              h24;
    logic                              adv;
    logic                              cur_pm;
    logic                              nxt_pm;

    assign freeze   = ctrl_q[CTRL_FREEZE];
    assign bin_mode = ctrl_q[CTRL_BIN];
    assign h24      = ctrl_q[CTRL_H24];
    assign cur_pm   = field_q[SL_HOUR][7] & ~h24;

    // Control byte: loaded by the host only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_RESET;
        end else if (wr_en && (wr_addr == CTRL_ADDR)) begin
            ctrl_q <= wr_data;
        end
    end

    tod_uip_sequencer #(
        .LEAD_CYC(LEAD_CYC),
        .BUSY_CYC(BUSY_CYC)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick_1hz),
        .freeze  (freeze),
        .uip     (uip_o),
        .adv     (adv),
        .upd_end (upd_end_o)
    );

    tod_calendar_next u_next (
        .h24     (h24),
        .sec     (dec[SL_SEC]),
        .min     (dec[SL_MIN]),
        .hr      (dec[SL_HOUR]),
        .pm      (cur_pm),
        .wday    (dec[SL_WDAY]),
        .mday    (dec[SL_MDAY]),
        .month   (dec[SL_MONTH]),
        .year    (dec[SL_YEAR]),
        .n_sec   (nxt[SL_SEC]),
        .n_min   (nxt[SL_MIN]),
        .n_hr    (nxt[SL_HOUR]),
        .n_pm    (nxt_pm),
        .n_wday  (nxt[SL_WDAY]),
        .n_mday  (nxt[SL_MDAY]),
        .n_month (nxt[SL_MONTH]),
        .n_year  (nxt[SL_YEAR])
    );

    for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_slot
        logic [BYTE_W-1:0] slot_q;
        logic              wr_hit;

        assign wr_hit     = wr_en && (wr_addr == slot_addr(g));
        assign field_q[g] = slot_q;

        tod_field_codec #(
            .IS_HOUR(g == SL_HOUR)
        ) u_codec (
            .raw      (slot_q),
            .bin_mode (bin_mode),
            .nxt      (nxt[g]),
            .nxt_pm   (nxt_pm),
            .dec      (dec[g]),
            .enc      (enc[g])
        );

        // Field byte: host write first, then the one-second advance.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_q <= slot_reset(g);
            end else if (wr_hit) begin
                slot_q <= wr_data;
            end else if (adv) begin
                slot_q <= enc[g];
            end
        end
    end

    assign sec_o   = field_q[SL_SEC];
    assign min_o   = field_q[SL_MIN];
    assign hour_o  = field_q[SL_HOUR];
    assign wday_o  = field_q[SL_WDAY];
    assign mday_o  = field_q[SL_MDAY];
    assign month_o = field_q[SL_MONTH];
    assign year_o  = field_q[SL_YEAR];

    AST_SEC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!uip_o && !(wr_en && wr_addr == 4'd0)) |=> $stable(sec_o)) else $error("seconds moved while idle"); // R3
    AST_MIN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 4'd2) |=> (min_o == $past(wr_data))) else $error("minute write lost"); // R6

endmodule

// File: tb/tod_update_engine_test.sv
`timescale 1ns/1ps
// Bench: a behavioural model runs beside the design and every output is
// compared on every falling edge; directed scenarios add literal checks.
module tod_update_engine_test;

    localparam int LEAD = 3;
    localparam int BUSY = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_1hz = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_addr = 4'd0;
    logic [7:0] wr_data = 8'd0;
    logic [7:0] sec_o, min_o, hour_o, wday_o, mday_o, month_o, year_o;
    logic       uip_o, upd_end_o;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    tod_update_engine #(.LEAD_CYC(LEAD), .BUSY_CYC(BUSY)) uut (
        .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .wday_o(wday_o),
        .mday_o(mday_o), .month_o(month_o), .year_o(year_o),
        .uip_o(uip_o), .upd_end_o(upd_end_o)
    );

    // ---------------- reference model ----------------
    int        m_phase;     // 0 idle, 1 warning, 2 busy
    int        m_left;
    bit        m_uip, m_end;
    bit [7:0]  m_f [7];
    bit [7:0]  m_ctrl;

    function automatic int to_int(bit [7:0] v, bit bin);
        return bin ? int'(v) : int'(v[7:4]) * 10 + int'(v[3:0]);
    endfunction

    function automatic bit [7:0] to_byte(int v, bit bin);
        return bin ? 8'(v) : 8'(((v / 10) << 4) | (v % 10));
    endfunction

    function automatic int dim(int mo, int y);
        if (mo == 2) return (y % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    task automatic model_tick_second();
        bit bin = m_ctrl[2];
        bit h24 = m_ctrl[1];
        int s = to_int(m_f[0], bin);
        int mi = to_int(m_f[1], bin);
        int h = to_int(m_f[2] & 8'h7f, bin);
        bit pm = m_f[2][7] & !h24;
        int wd = to_int(m_f[3], bin);
        int md = to_int(m_f[4], bin);
        int mo = to_int(m_f[5], bin);
        int y = to_int(m_f[6], bin);
        bit day = 0;
        s = s + 1;
        if (s == 60) begin
            s = 0;
            mi = mi + 1;
            if (mi == 60) begin
                mi = 0;
                if (h24) begin
                    h = h + 1;
                    if (h == 24) begin h = 0; day = 1; end
                end else if (h == 12) begin
                    h = 1;
                end else begin
                    h = h + 1;
                    if (h == 12) begin day = pm; pm = !pm; end
                end
            end
        end
        if (day) begin
            wd = wd % 7 + 1;
            md = md + 1;
            if (md > dim(mo, y)) begin
                md = 1;
                mo = mo + 1;
                if (mo > 12) begin mo = 1; y = (y + 1) % 100; end
            end
        end
        m_f[0] = to_byte(s, bin);
        m_f[1] = to_byte(mi, bin);
        m_f[2] = to_byte(h, bin) | {pm, 7'd0};
        m_f[3] = to_byte(wd, bin);
        m_f[4] = to_byte(md, bin);
        m_f[5] = to_byte(mo, bin);
        m_f[6] = to_byte(y, bin);
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0; m_left = 0; m_uip = 0; m_end = 0; m_ctrl = 8'h02;
            m_f[0] = 0; m_f[1] = 0; m_f[2] = 0; m_f[3] = 1;
            m_f[4] = 1; m_f[5] = 1; m_f[6] = 0;
        end else begin
            m_end = 0;
            if (m_ctrl[7]) begin
                m_phase = 0; m_uip = 0;
            end else if (m_phase == 0) begin
                if (tick_1hz) begin m_phase = 1; m_left = LEAD; m_uip = 1; end
            end else begin
                m_left = m_left - 1;
                if (m_left == 0 && m_phase == 1) begin
                    model_tick_second();
                    m_phase = 2; m_left = BUSY;
                end else if (m_left == 0 && m_phase == 2) begin
                    m_phase = 0; m_uip = 0; m_end = 1;
                end
            end
            if (wr_en) begin
                case (wr_addr)
                    4'd0: m_f[0] = wr_data;
                    4'd2: m_f[1] = wr_data;
                    4'd4: m_f[2] = wr_data;
                    4'd6: m_f[3] = wr_data;
                    4'd7: m_f[4] = wr_data;
                    4'd8: m_f[5] = wr_data;
                    4'd9: m_f[6] = wr_data;
                    4'd11: m_ctrl = wr_data;
                    default: ;
                endcase
            end
        end
    end

    // ---------------- checking ----------------
    task automatic chk(string tag, string what, logic [7:0] got, logic [7:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h at %0t", tag, what, got, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model.
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R2", "uip", {7'd0, uip_o}, {7'd0, m_uip});
            chk("R4", "upd_end", {7'd0, upd_end_o}, {7'd0, m_end});
            chk("R3", "sec", sec_o, m_f[0]);
            chk("R3", "min", min_o, m_f[1]);
            chk("R3", "hour", hour_o, m_f[2]);
            chk("R3", "wday", wday_o, m_f[3]);
            chk("R3", "mday", mday_o, m_f[4]);
            chk("R3", "month", month_o, m_f[5]);
            chk("R3", "year", year_o, m_f[6]);
        end
    end

    task automatic wr(logic [3:0] a, logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_time(logic [7:0] h, logic [7:0] m, logic [7:0] s);
        wr(4'd4, h); wr(4'd2, m); wr(4'd0, s);
    endtask

    task automatic set_date(logic [7:0] wd, logic [7:0] md, logic [7:0] mo, logic [7:0] y);
        wr(4'd6, wd); wr(4'd7, md); wr(4'd8, mo); wr(4'd9, y);
    endtask

    task automatic one_update();
        @(negedge clk); tick_1hz = 1'b1;
        @(negedge clk); tick_1hz = 1'b0;
        repeat (LEAD + BUSY + 2) @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1", "sec", sec_o, 8'h00);
        chk("R1", "hour", hour_o, 8'h00);
        chk("R1", "wday", wday_o, 8'h01);
        chk("R1", "mday", mday_o, 8'h01);
        chk("R1", "month", month_o, 8'h01);
        chk("R1", "uip", {7'd0, uip_o}, 8'h00);
        chk("R1", "upd_end", {7'd0, upd_end_o}, 8'h00);

        // R2 and R4 timing: flag one cycle after tick, end pulse at fall
        @(negedge clk); tick_1hz = 1'b1;
        @(negedge clk); tick_1hz = 1'b0;
        chk("R2", "uip after tick", {7'd0, uip_o}, 8'h01);
        repeat (LEAD - 1) @(negedge clk);
        chk("R3", "sec before advance", sec_o, 8'h00);
        @(negedge clk);
        chk("R3", "sec after advance", sec_o, 8'h01);
        tick_1hz = 1'b1;            // R2: ignored while busy
        @(negedge clk); tick_1hz = 1'b0;
        repeat (BUSY - 2) @(negedge clk);
        chk("R4", "uip before fall", {7'd0, uip_o}, 8'h01);
        @(negedge clk);
        chk("R4", "end pulse", {7'd0, upd_end_o}, 8'h01);
        @(negedge clk);
        chk("R4", "end pulse one cycle", {7'd0, upd_end_o}, 8'h00);
        chk("R2", "late tick ignored", sec_o, 8'h01);

        // R7 R8 R10 R11: full BCD carry chain in 24-hour form
        set_time(8'h23, 8'h59, 8'h59);
        set_date(8'h07, 8'h31, 8'h12, 8'h99);
        one_update();
        chk("R8", "hour wrap", hour_o, 8'h00);
        chk("R7", "bcd sec wrap", sec_o, 8'h00);
        chk("R11", "wday wrap", wday_o, 8'h01);
        chk("R10", "mday wrap", mday_o, 8'h01);
        chk("R11", "month wrap", month_o, 8'h01);
        chk("R11", "year wrap", year_o, 8'h00);

        // R10: February and a 30-day month
        set_time(8'h23, 8'h59, 8'h59); set_date(8'h02, 8'h28, 8'h02, 8'h23);
        one_update();
        chk("R10", "feb 28 non-leap", mday_o, 8'h01);
        chk("R10", "march", month_o, 8'h03);
        set_time(8'h23, 8'h59, 8'h59); set_date(8'h02, 8'h28, 8'h02, 8'h24);
        one_update();
        chk("R10", "feb 29 leap", mday_o, 8'h29);
        set_time(8'h23, 8'h59, 8'h59);
        one_update();
        chk("R10", "after feb 29", month_o, 8'h03);
        set_time(8'h23, 8'h59, 8'h59); set_date(8'h03, 8'h30, 8'h04, 8'h24);
        one_update();
        chk("R10", "april 30", mday_o, 8'h01);
        set_time(8'h23, 8'h59, 8'h59); set_date(8'h03, 8'h30, 8'h01, 8'h24);
        one_update();
        chk("R10", "jan 30", mday_o, 8'h31);

        // R7: BCD digit carry, then binary mode
        set_time(8'h10, 8'h00, 8'h09);
        one_update();
        chk("R7", "bcd 09", sec_o, 8'h10);
        wr(4'd11, 8'h06);
        set_time(8'h17, 8'h3B, 8'h3B); set_date(8'h03, 8'h1F, 8'h07, 8'h05);
        one_update();
        chk("R7", "binary sec wrap", sec_o, 8'h00);
        chk("R8", "binary hour wrap", hour_o, 8'h00);
        chk("R10", "binary july 31", month_o, 8'h08);
        set_time(8'h01, 8'h00, 8'h09);
        one_update();
        chk("R7", "binary 09", sec_o, 8'h0A);

        // R9: 12-hour form, binary then BCD
        wr(4'd11, 8'h04);
        set_time(8'h8B, 8'h3B, 8'h3B);
        one_update();
        chk("R9", "binary 11pm", hour_o, 8'h0C);
        wr(4'd11, 8'h00);
        set_time(8'h11, 8'h59, 8'h59);
        one_update();
        chk("R9", "11am to 12pm", hour_o, 8'h92);
        wr(4'd2, 8'h59); wr(4'd0, 8'h59);
        one_update();
        chk("R9", "12pm to 1pm", hour_o, 8'h81);
        set_time(8'h91, 8'h59, 8'h59); set_date(8'h04, 8'h10, 8'h05, 8'h30);
        one_update();
        chk("R9", "11pm to 12am", hour_o, 8'h12);
        chk("R9", "day carry", mday_o, 8'h11);

        // R6: unused addresses ignored
        wr(4'd11, 8'h02);
        set_time(8'h08, 8'h30, 8'h15);
        wr(4'd1, 8'h55); wr(4'd3, 8'h55); wr(4'd5, 8'h55); wr(4'd10, 8'h55);
        chk("R6", "sec unchanged", sec_o, 8'h15);
        chk("R6", "min unchanged", min_o, 8'h30);
        chk("R6", "hour unchanged", hour_o, 8'h08);

        // R6: write on the advance edge wins for its field
        wr(4'd0, 8'h59);
        @(negedge clk); tick_1hz = 1'b1;
        @(negedge clk); tick_1hz = 1'b0;
        repeat (LEAD - 1) @(negedge clk);
        wr_en = 1'b1; wr_addr = 4'd0; wr_data = 8'h42;
        @(negedge clk); wr_en = 1'b0;
        chk("R6", "collision sec", sec_o, 8'h42);
        chk("R6", "collision min carried", min_o, 8'h31);
        repeat (BUSY + 2) @(negedge clk);

        // R5: freeze blocks a tick
        wr(4'd11, 8'h82);
        one_update();
        chk("R5", "frozen sec", sec_o, 8'h42);
        chk("R5", "frozen uip", {7'd0, uip_o}, 8'h00);

        // R5: freeze inside the warning window cancels the update
        wr(4'd11, 8'h02);
        @(negedge clk); tick_1hz = 1'b1;
        @(negedge clk); tick_1hz = 1'b0;
        wr_en = 1'b1; wr_addr = 4'd11; wr_data = 8'h82;
        @(negedge clk); wr_en = 1'b0;
        @(negedge clk);
        chk("R5", "cancel uip", {7'd0, uip_o}, 8'h00);
        repeat (LEAD + BUSY) @(negedge clk);
        chk("R5", "cancel sec", sec_o, 8'h42);
        chk("R5", "cancel no end", {7'd0, upd_end_o}, 8'h00);

        repeat (3) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule